// File: doc/BRIEF.md
# Mirrored Memory-Configuration Register Bank

This block is the processor-facing register file of a small memory management unit in an 8-bit system. It keeps one live memory-configuration byte, four stored configuration presets, a mode byte and a fixed identification byte. Software reaches these through a 256-byte register page in the I/O area. The live configuration byte and the presets can also be reached through a short group of addresses near the top of the address space, which is never hidden.

The live configuration byte is a single register that can be reached at two addresses. The page copy decodes only while the I/O area is mapped in. The top copy decodes at all times. A write to one of the four addresses just above the top copy is a preset trigger. It loads the matching preset into the live configuration, and the data on the bus during that write does not matter. One bit of the mode byte removes the whole register page from the bus, and only a reset brings it back.

Reads are combinational from the address. Writes land on the rising clock edge on which `cpu_wr` is sampled high. The live configuration and the mode byte are also driven out as register outputs for the address translation logic that sits next to this block.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the live configuration is 0x00, every preset is 0x00, `mode_out` reads 0x06 and `win_visible` is 1.
- R2: A write to the top configuration address (0xFF00) replaces the live configuration on the next clock edge, whatever the state of `io_visible`. Reading 0xFF00 returns the live value, with `rd_hit` set.
- R3: Page offset 0x00 (address 0xD500) is the same live configuration register. It reads and writes only while `io_visible` is 1. While `io_visible` is 0, the whole page gives `rd_hit`=0 with `rd_data`=0x00, and writes to it leave every register unchanged.
- R4: Page offsets 0x01 to 0x04 hold presets 0 to 3 and can be read and written. Reading top addresses 0xFF01 to 0xFF04 returns presets 0 to 3.
- R5: A write of any data to 0xFF01+k (k = 0..3) copies preset k into the live configuration on that clock edge.
- R6: When a direct configuration write and a preset trigger fall on consecutive cycles, the live configuration holds the result of the later one.
- R7: The mode byte sits at page offset 0x05. Bit 0 is the processor select and is 0 after reset. Bits 1 and 2 always read 1 and ignore writes. All other bits store what is written.
- R8: When mode bit 6 is 1, `win_visible` is 0. Page addresses then give `rd_hit`=0 and ignore writes, so the bit can only be cleared by reset. The top addresses keep working.
- R9: Page offset 0x06 reads 0x20 (RAM block count 2 in bits 7:4, revision 0 in bits 3:0), and writes to it change nothing.
- R10: Page offsets 0x07 to 0xFF read 0xFF with `rd_hit`=1, and writes to them change nothing.
- R11: Any address outside the page and outside 0xFF00 to 0xFF04 gives `rd_hit`=0 and `rd_data`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_wdata | input | 8 | Write data |
| io_visible | input | 1 | High while the I/O area is mapped in, which enables the page copy |
| rd_data | output | 8 | Combinational read data for `cpu_addr` |
| rd_hit | output | 1 | `cpu_addr` decodes to a register of this block |
| cfg_out | output | 8 | Live memory configuration |
| mode_out | output | 8 | Mode byte as read back, including the fixed ones in bits 1 and 2 |
| win_visible | output | 1 | Register page is still decodable (mode bit 6 clear) |

## Verification
A write moves the registers on the single edge that samples the strobe. `cfg_out`, `mode_out` and `win_visible` therefore change one cycle after the write is presented, and a read of the same register reflects the new value at the following falling edge. `rd_data` and `rd_hit` have no register between them and the address, so they are due in the same cycle the address is driven. The bench drives every input on a falling edge and samples one time unit later. For the back-to-back case it samples between the two writes as well as after them, which confirms that the first write had already landed before the second one replaced it.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int DW = 8;

  // decoded register kind for one bus address
  typedef enum logic [2:0] {
    K_NONE,
    K_CFG,
    K_PRE,
    K_LOAD,
    K_MODE,
    K_VER,
    K_UNUSED
  } kind_e;

  localparam int          MODE_HIDE_BIT   = 6;
  localparam logic [DW-1:0] MODE_FIXED_ONES = 8'h06;
  localparam logic [DW-1:0] UNUSED_READ     = 8'hFF;
  localparam logic [DW-1:0] MISS_READ       = 8'h00;

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                LO_OFF_W = 8,
  parameter logic [ADDR_W-1:0] LO_BASE  = 16'hD500,
  parameter logic [ADDR_W-1:0] HI_BASE  = 16'hFF00,
  parameter int                NUM_PRE  = 4,
  parameter int                IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_visible,
  input  logic              win_visible,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0]   HI_LAST  = ADDR_W'(HI_BASE + NUM_PRE);
  localparam logic [LO_OFF_W-1:0] OFF_PRE  = LO_OFF_W'(NUM_PRE);
  localparam logic [LO_OFF_W-1:0] OFF_MODE = LO_OFF_W'(NUM_PRE + 1);
  localparam logic [LO_OFF_W-1:0] OFF_VER  = LO_OFF_W'(NUM_PRE + 2);

  logic [LO_OFF_W-1:0] off;
  logic                page_hit;

  assign off      = addr[LO_OFF_W-1:0];
  assign page_hit = (addr[ADDR_W-1:LO_OFF_W] == LO_BASE[ADDR_W-1:LO_OFF_W])
                    && io_visible && win_visible;

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (addr == HI_BASE) begin
      kind = K_CFG;
    end else if (addr > HI_BASE && addr <= HI_LAST) begin
      kind = K_LOAD;
      idx  = IDX_W'(addr - HI_BASE - ADDR_W'(1));
    end else if (page_hit) begin
      if (off == '0) begin
        kind = K_CFG;
      end else if (off <= OFF_PRE) begin
        kind = K_PRE;
        idx  = IDX_W'(off - LO_OFF_W'(1));
      end else if (off == OFF_MODE) begin
        kind = K_MODE;
      end else if (off == OFF_VER) begin
        kind = K_VER;
      end else begin
        kind = K_UNUSED;
      end
    end
  end

endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
#(
  parameter int NUM_PRE = 4,
  parameter int IDX_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  kind_e                 kind,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         cfg_q,
  output logic [DW-1:0]         mode_q,
  output logic [NUM_PRE*DW-1:0] pre_flat
);

  logic [DW-1:0] pre_q [NUM_PRE];

  // one storage byte per preset
  for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
    always_ff @(posedge clk) begin
      if (rst)
        pre_q[g] <= '0;
      else if (wr && kind == K_PRE && idx == IDX_W'(g))
        pre_q[g] <= wdata;
    end
    assign pre_flat[g*DW +: DW] = pre_q[g];
  end

  // live configuration: direct write or preset transfer
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (wr && kind == K_CFG)
      cfg_q <= wdata;
    else if (wr && kind == K_LOAD)
      cfg_q <= pre_q[idx];
  end

  // mode byte: fixed-one bits are never stored
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= '0;
    else if (wr && kind == K_MODE)
      mode_q <= wdata & ~MODE_FIXED_ONES;
  end

endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux
  import cfgbank_pkg::*;
#(
  parameter int NUM_PRE = 4,
  parameter int IDX_W   = 2
) (
  input  kind_e                 kind,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DW-1:0]         cfg_q,
  input  logic [DW-1:0]         mode_view,
  input  logic [NUM_PRE*DW-1:0] pre_flat,
  input  logic [DW-1:0]         version,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_hit
);

  logic [DW-1:0] pre_sel;

  assign pre_sel = pre_flat[idx*DW +: DW];

  always_comb begin
    rd_hit = 1'b1;
    unique case (kind)
      K_CFG:          rd_data = cfg_q;
      K_PRE, K_LOAD:  rd_data = pre_sel;
      K_MODE:         rd_data = mode_view;
      K_VER:          rd_data = version;
      K_UNUSED:       rd_data = UNUSED_READ;
      default: begin
        rd_data = MISS_READ;
        rd_hit  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                LO_OFF_W   = 8,
  parameter logic [ADDR_W-1:0] LO_BASE    = 16'hD500,
  parameter logic [ADDR_W-1:0] HI_BASE    = 16'hFF00,
  parameter int                NUM_PRE    = 4,
  parameter int                RAM_BLOCKS = 2,
  parameter int                REVISION   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic              io_visible,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  output logic [7:0]        cfg_out,
  output logic [7:0]        mode_out,
  output logic              win_visible
);

  localparam int            IDX_W   = (NUM_PRE > 1) ? $clog2(NUM_PRE) : 1;
  localparam logic [DW-1:0] VERSION = {4'(RAM_BLOCKS), 4'(REVISION)};

  kind_e                 kind;
  logic [IDX_W-1:0]      idx;
  logic [DW-1:0]         cfg_q;
  logic [DW-1:0]         mode_q;
  logic [NUM_PRE*DW-1:0] pre_flat;
  logic [DW-1:0]         mode_view;

  assign mode_view   = mode_q | MODE_FIXED_ONES;
  assign win_visible = ~mode_q[MODE_HIDE_BIT];
  assign cfg_out     = cfg_q;
  assign mode_out    = mode_view;

  cfgbank_decode #(
    .ADDR_W   (ADDR_W),
    .LO_OFF_W (LO_OFF_W),
    .LO_BASE  (LO_BASE),
    .HI_BASE  (HI_BASE),
    .NUM_PRE  (NUM_PRE),
    .IDX_W    (IDX_W)
  ) u_dec (
    .addr        (cpu_addr),
    .io_visible  (io_visible),
    .win_visible (win_visible),
    .kind        (kind),
    .idx         (idx)
  );

  cfgbank_regs #(
    .NUM_PRE (NUM_PRE),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (cpu_wr),
    .kind     (kind),
    .idx      (idx),
    .wdata    (cpu_wdata),
    .cfg_q    (cfg_q),
    .mode_q   (mode_q),
    .pre_flat (pre_flat)
  );

  cfgbank_rdmux #(
    .NUM_PRE (NUM_PRE),
    .IDX_W   (IDX_W)
  ) u_rd (
    .kind      (kind),
    .idx       (idx),
    .cfg_q     (cfg_q),
    .mode_view (mode_view),
    .pre_flat  (pre_flat),
    .version   (VERSION),
    .rd_data   (rd_data),
    .rd_hit    (rd_hit)
  );

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                LO_OFF_W = 8,
  parameter logic [ADDR_W-1:0] LO_BASE  = 16'hD500,
  parameter logic [ADDR_W-1:0] HI_BASE  = 16'hFF00,
  parameter int                NUM_PRE  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic              rd_hit,
  input logic [7:0]        cfg_out,
  input logic [7:0]        mode_out,
  input logic              win_visible,
  input logic [NUM_PRE*8-1:0] pre_flat
);

  logic on_page;
  logic page_dead_off;

  assign on_page = cpu_addr[ADDR_W-1:LO_OFF_W] == LO_BASE[ADDR_W-1:LO_OFF_W];
  assign page_dead_off = on_page &&
                         (cpu_addr[LO_OFF_W-1:0] >= LO_OFF_W'(NUM_PRE + 2));

  // R1: values right after reset is released
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_out == 8'h00 && mode_out == 8'h06 && win_visible));

  // R2: top copy write lands on the next edge
  p_top_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == HI_BASE) |=> cfg_out == $past(cpu_wdata));

  // R5: preset trigger copies the matching preset
  for (genvar g = 0; g < NUM_PRE; g++) begin : g_ld
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && cpu_addr == ADDR_W'(HI_BASE + g + 1))
      |=> cfg_out == $past(pre_flat[g*8 +: 8]));
  end

  // R7: fixed-one bits of the mode byte
  p_mode_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    mode_out[2:1] == 2'b11);

  // R8: hiding is sticky until reset
  p_hide_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !win_visible |=> !win_visible);

  // R8: hidden page never answers
  p_hidden_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (!win_visible && on_page) |-> !rd_hit);

  // R9 and R10: writes to the identification byte or empty offsets change nothing
  p_dead_write_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && page_dead_off) |=> ($stable(cfg_out) && $stable(mode_out)));

endmodule

bind cfgbank_top cfgbank_chk #(
  .ADDR_W   (ADDR_W),
  .LO_OFF_W (LO_OFF_W),
  .LO_BASE  (LO_BASE),
  .HI_BASE  (HI_BASE),
  .NUM_PRE  (NUM_PRE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .cpu_wr      (cpu_wr),
  .cpu_wdata   (cpu_wdata),
  .rd_hit      (rd_hit),
  .cfg_out     (cfg_out),
  .mode_out    (mode_out),
  .win_visible (win_visible),
  .pre_flat    (pre_flat)
);

// File: tb/sim_cfgbank_top.sv
`timescale 1ns/1ps
module sim_cfgbank_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        io_visible = 1'b1;
  logic [7:0]  rd_data;
  logic        rd_hit;
  logic [7:0]  cfg_out;
  logic [7:0]  mode_out;
  logic        win_visible;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfgbank_top u0 (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .io_visible  (io_visible),
    .rd_data     (rd_data),
    .rd_hit      (rd_hit),
    .cfg_out     (cfg_out),
    .mode_out    (mode_out),
    .win_visible (win_visible)
  );

  // {wr, io, waddr, wdata, raddr, exp_hit, exp_data, req}
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1,1'b1,16'hFF00,8'h5A,16'hD500,1'b1,8'h5A,4'd2},  // R2
    {1'b1,1'b1,16'hD501,8'h11,16'hD501,1'b1,8'h11,4'd4},  // R4
    {1'b1,1'b1,16'hD502,8'h22,16'hD502,1'b1,8'h22,4'd4},  // R4
    {1'b1,1'b1,16'hD503,8'h33,16'hFF03,1'b1,8'h33,4'd4},  // R4
    {1'b1,1'b1,16'hD504,8'h44,16'hD504,1'b1,8'h44,4'd4},  // R4
    {1'b1,1'b1,16'hFF02,8'h99,16'hFF00,1'b1,8'h22,4'd5},  // R5
    {1'b1,1'b1,16'hFF04,8'h00,16'hD500,1'b1,8'h44,4'd5},  // R5
    {1'b1,1'b1,16'hD500,8'h77,16'hFF00,1'b1,8'h77,4'd3},  // R3
    {1'b1,1'b0,16'hD500,8'h88,16'hFF00,1'b1,8'h77,4'd3},  // R3
    {1'b0,1'b0,16'h0000,8'h00,16'hD500,1'b0,8'h00,4'd3},  // R3
    {1'b1,1'b1,16'hD506,8'hAB,16'hD506,1'b1,8'h20,4'd9},  // R9
    {1'b1,1'b1,16'hD5F0,8'h12,16'hD5F0,1'b1,8'hFF,4'd10}, // R10
    {1'b1,1'b1,16'hD507,8'h12,16'hFF00,1'b1,8'h77,4'd10}, // R10
    {1'b1,1'b1,16'hD505,8'h31,16'hD505,1'b1,8'h37,4'd7},  // R7
    {1'b1,1'b1,16'hD505,8'h00,16'hD505,1'b1,8'h06,4'd7},  // R7
    {1'b0,1'b1,16'h0000,8'h00,16'h1234,1'b0,8'h00,4'd11}  // R11
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write_cyc(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a,
                          input logic hit, input logic [7:0] exp);
    cpu_addr = a;
    #1;
    check(req, {7'd0, rd_hit}, {7'd0, hit});
    check(req, rd_data, exp);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", cfg_out, 8'h00);
    check("R1", mode_out, 8'h06);
    check("R1", {7'd0, win_visible}, 8'h01);
    for (int k = 1; k <= 4; k++) read_chk("R1", 16'hD500 + 16'(k), 1'b1, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      cpu_addr   = v[52:37];
      cpu_wdata  = v[36:29];
      cpu_wr     = v[54];
      io_visible = v[53];
      @(negedge clk);
      cpu_wr = 1'b0;
      read_chk(rq, v[28:13], v[12], v[11:4]);
    end
    io_visible = 1'b1;

    // R6: direct write then trigger on consecutive edges
    @(negedge clk);
    cpu_addr = 16'hFF00; cpu_wdata = 8'h10; cpu_wr = 1'b1;
    @(negedge clk);
    #1 check("R6", cfg_out, 8'h10);
    cpu_addr = 16'hFF01; cpu_wdata = 8'hEE;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1 check("R6", cfg_out, 8'h11);
    // R6: trigger then direct write
    @(negedge clk);
    cpu_addr = 16'hFF01; cpu_wdata = 8'h00; cpu_wr = 1'b1;
    @(negedge clk);
    #1 check("R6", cfg_out, 8'h11);
    cpu_addr = 16'hFF00; cpu_wdata = 8'h55;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1 check("R6", cfg_out, 8'h55);

    // R8: hide the page
    write_cyc(16'hD505, 8'h40);
    #1;
    check("R8", {7'd0, win_visible}, 8'h00);
    check("R8", mode_out, 8'h46);
    read_chk("R8", 16'hD500, 1'b0, 8'h00);
    write_cyc(16'hD505, 8'h00);
    #1 check("R8", mode_out, 8'h46);
    write_cyc(16'hD501, 8'hAA);
    read_chk("R8", 16'hFF01, 1'b1, 8'h11);
    write_cyc(16'hFF00, 8'h3C);
    read_chk("R8", 16'hFF00, 1'b1, 8'h3C);

    // R1: reset brings the page back and clears state
    pulse_reset();
    #1;
    check("R1", {7'd0, win_visible}, 8'h01);
    check("R1", cfg_out, 8'h00);
    read_chk("R1", 16'hD501, 1'b1, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule